// File: doc/BRIEF.md
# Programmable Settle Pulse Generator

This block drives the fast-settle control of a read preamplifier. When the read path is about to see a DC step, it raises a single settle-active output for a programmed time. Such a step comes from selecting another head, rewriting the bias-current setting, waking from standby into read, or returning from write to read while the read stage was powered down. The analog settling circuit that consumes the output is outside this block.

The pulse length is a non-linear function of a 3-bit code held in an internal register: 2 µs plus 1/(code+1) µs. The length runs from 3 µs for code 0 (the value after reset) down to 2.125 µs for code 7. Each of the eight lengths is converted at elaboration time into a whole number of clock cycles, rounded to the nearest cycle, for the clock frequency given as a parameter. A pulse is only produced while the part is in active read. Sleep, standby and write suppress it and discard any trigger that arrives in them.

Top module: `settle_pulse_gen`

## Requirements
- R1: After reset the output `settle_o` is low and the code register holds 0, so the first pulse lasts the code-0 length.
- R2: A pulse lasts round(CLK_HZ × (2 + 1/(code+1)) µs) cycles, rounding halves upward; at 50 MHz codes 0 to 7 give 150, 125, 117, 113, 110, 108, 107 and 106 cycles. The output rises in the cycle after the triggering edge and stays high for exactly that many cycles.
- R3: A `head_chg` strobe sampled while in active read (`pwr_mode` = 2'b11 and `rd_wr_n` = 1) starts a pulse.
- R4: A `bias_wr` strobe sampled while in active read starts a pulse.
- R5: Entering active read directly from standby (`pwr_mode` 2'b01 or 2'b10 on the previous edge) starts a pulse. Entering it from sleep (2'b00) does not.
- R6: Entering active read from active write (`pwr_mode` 2'b11 with `rd_wr_n` = 0 on the previous edge) starts a pulse when `keep_biased` is 0 and does not when it is 1. Head-change and bias strobes still trigger with `keep_biased` = 1.
- R7: A trigger that arrives during a running pulse restarts the full length from that trigger.
- R8: Outside active read `settle_o` is low, any strobe is discarded, and a running pulse is cut off and does not resume when the part returns to read.
- R9: `code_wr` loads `code_din` into the code register. A pulse takes its length from the value the register holds at the triggering edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_mode | input | 2 | 00 sleep, 01/10 standby, 11 active |
| rd_wr_n | input | 1 | 1 read, 0 write (meaningful in active) |
| keep_biased | input | 1 | Read stage kept powered during write |
| head_chg | input | 1 | One-cycle strobe: selected head changed |
| bias_wr | input | 1 | One-cycle strobe: bias-current setting rewritten |
| code_wr | input | 1 | Load strobe for the settle-length code |
| code_din | input | 3 | New settle-length code |
| settle_o | output | 1 | Settle-active output |

## Verification
On every cycle the assertions check four things. The output never rises without a trigger. The counter never exceeds the longest length and counts down by one while no trigger arrives. A sleep-to-read entry, or a write-to-read entry with the read stage kept biased, leaves the counter idle when no strobe comes with it. Exact pulse lengths for each code, the restart of a running pulse and the loss of a pulse cut off by a mode change can only be shown by the bench. It drives directed scenarios and measures lengths against values computed from the formula, and then runs long random mode and strobe sequences compared cycle by cycle with a reference model.

// File: rtl/settle_pulse_gen.sv
module settle_pulse_gen #(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        pwr_mode,
  input  logic              rd_wr_n,
  input  logic              keep_biased,
  input  logic              head_chg,
  input  logic              bias_wr,
  input  logic              code_wr,
  input  logic [CODE_W-1:0] code_din,
  output logic              settle_o
);

  function automatic int unsigned width_cyc(int unsigned c);
    longint unsigned num, den;
    num = longint'(CLK_HZ) * longint'(2 * (c + 1) + 1);
    den = longint'(c + 1) * 64'd1_000_000;
    return int'((2 * num + den) / (2 * den));
  endfunction

  localparam int unsigned NCODE = 1 << CODE_W;
  localparam int unsigned WMAX  = width_cyc(0);
  localparam int unsigned CW    = $clog2(WMAX + 1);

  localparam logic [1:0] PM_SLEEP  = 2'b00;
  localparam logic [1:0] PM_ACTIVE = 2'b11;

  logic [CW-1:0] wtab [NCODE];

  for (genvar g = 0; g < NCODE; g++) begin : g_wtab
    assign wtab[g] = CW'(width_cyc(g));
  end

  logic [CODE_W-1:0] code_q;
  logic [CW-1:0]     cnt;
  logic [1:0]        prev_pm;
  logic              prev_rd;

  wire act_rd   = (pwr_mode == PM_ACTIVE) && rd_wr_n;
  wire was_stby = (prev_pm != PM_SLEEP) && (prev_pm != PM_ACTIVE);
  wire was_wr   = (prev_pm == PM_ACTIVE) && !prev_rd;
  wire trg      = act_rd && (head_chg || bias_wr || was_stby || (was_wr && !keep_biased));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      cnt     <= '0;
      prev_pm <= PM_SLEEP;
      prev_rd <= 1'b1;
    end else begin
      prev_pm <= pwr_mode;
      prev_rd <= rd_wr_n;
      if (code_wr) code_q <= code_din;
      if (!act_rd)          cnt <= '0;
      else if (trg)         cnt <= wtab[code_q];
      else if (cnt != '0)   cnt <= cnt - 1'b1;
    end
  end

  assign settle_o = (cnt != '0) && act_rd;

  // R3
  rise_needs_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(settle_o) |-> $past(trg));

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= wtab[0]);

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && !trg && act_rd) |=> cnt == $past(cnt) - 1'b1);

  // R5
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_rd && prev_pm == PM_SLEEP && !head_chg && !bias_wr && cnt == '0) |=> cnt == '0);

  // R6
  keep_biased_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_rd && was_wr && keep_biased && !head_chg && !bias_wr && cnt == '0) |=> cnt == '0);

  // R9
  code_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(code_wr) |-> code_q == $past(code_din));

endmodule

// File: tb/tb_settle_pulse_gen.sv
module tb_settle_pulse_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] pwr_mode = 2'b00;
  logic rd_wr_n = 1'b1, keep_biased = 1'b0;
  logic head_chg = 1'b0, bias_wr = 1'b0, code_wr = 1'b0;
  logic [2:0] code_din = 3'd0;
  logic settle_o;

  int total = 0, bad = 0;
  bit done = 0;

  settle_pulse_gen dut (.*);

  always #10 clk = ~clk;

  // reference model state
  int m_cnt = 0;
  logic [2:0] m_code = 3'd0;
  logic [1:0] m_pp = 2'b00;
  logic m_prd = 1'b1;

  function automatic int exp_w(int c);
    real us;
    us = 2.0 + 1.0 / real'(c + 1);
    return $rtoi(us * 50.0 + 0.5);
  endfunction

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: model update plus output compare; inputs held until return
  task automatic tick(input string tag);
    bit act, stby, wr, trg;
    act  = (pwr_mode == 2'b11) && rd_wr_n;
    stby = (m_pp == 2'b01) || (m_pp == 2'b10);
    wr   = (m_pp == 2'b11) && !m_prd;
    trg  = act && (head_chg || bias_wr || stby || (wr && !keep_biased));
    @(posedge clk);
    #1;
    if (!act) m_cnt = 0;
    else if (trg) m_cnt = exp_w(int'(m_code));
    else if (m_cnt > 0) m_cnt--;
    if (code_wr) m_code = code_din;
    m_pp = pwr_mode;
    m_prd = rd_wr_n;
    chk(settle_o == ((m_cnt != 0) && act), tag, int'(settle_o), int'((m_cnt != 0) && act));
    @(negedge clk);
    head_chg = 1'b0; bias_wr = 1'b0; code_wr = 1'b0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  // counts high cycles starting with the tick that applies current stimulus
  task automatic measure(output int n, input string tag);
    n = 0;
    tick(tag);
    while (settle_o && n < 400) begin
      n++;
      tick(tag);
    end
  endtask

  task automatic set_code(input int c);
    code_din = 3'(c); code_wr = 1'b1;
    tick("R9 load");
  endtask

  initial begin
    int n;
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    chk(settle_o == 1'b0, "R1 reset output", int'(settle_o), 0);
    rst_n = 1'b1;
    idle(2, "R1 idle");
    // R1 / R5: standby to active read, default code length
    pwr_mode = 2'b01; idle(3, "R5 standby");
    pwr_mode = 2'b11; rd_wr_n = 1'b1;
    measure(n, "R1 default");
    chk(n == 150, "R1 default length", n, 150);
    // R2: every code, triggered by head change
    for (int c = 0; c < 8; c++) begin
      set_code(c);
      head_chg = 1'b1;
      measure(n, "R2 code");
      chk(n == exp_w(c), $sformatf("R2 R3 code %0d length", c), n, exp_w(c));
    end
    // R4 bias strobe (code 7 still loaded)
    bias_wr = 1'b1;
    measure(n, "R4 bias");
    chk(n == 106, "R4 bias length", n, 106);
    // R5 sleep to read: no pulse
    pwr_mode = 2'b00; idle(3, "R5 sleep");
    pwr_mode = 2'b11; measure(n, "R5 from sleep");
    chk(n == 0, "R5 sleep entry no pulse", n, 0);
    // R5 other standby code
    pwr_mode = 2'b10; idle(2, "R5 stby10");
    pwr_mode = 2'b11; measure(n, "R5 stby10");
    chk(n == 106, "R5 standby 10 entry", n, 106);
    // R6 write to read, keep_biased 0 then 1
    set_code(1);
    keep_biased = 1'b0; rd_wr_n = 1'b0; idle(4, "R6 write");
    rd_wr_n = 1'b1; measure(n, "R6 wr2rd");
    chk(n == 125, "R6 write-to-read pulse", n, 125);
    keep_biased = 1'b1; rd_wr_n = 1'b0; idle(4, "R6 write kb");
    rd_wr_n = 1'b1; measure(n, "R6 wr2rd kb");
    chk(n == 0, "R6 keep-biased no pulse", n, 0);
    head_chg = 1'b1; measure(n, "R6 head kb");
    chk(n == 125, "R6 head change with keep-biased", n, 125);
    keep_biased = 1'b0;
    // R7 retrigger after 40 cycles
    head_chg = 1'b1; tick("R7 first");
    idle(40, "R7 run");
    bias_wr = 1'b1; measure(n, "R7 retrig");
    chk(n == 125, "R7 restart full length", n, 125);
    // R8 strobes outside read discarded, running pulse cut
    rd_wr_n = 1'b0; keep_biased = 1'b1;
    head_chg = 1'b1; tick("R8 write strobe");
    chk(settle_o == 1'b0, "R8 write strobe ignored", int'(settle_o), 0);
    rd_wr_n = 1'b1; measure(n, "R8 back");
    chk(n == 0, "R8 no pending pulse", n, 0);
    head_chg = 1'b1; tick("R8 start"); idle(10, "R8 run");
    pwr_mode = 2'b00; tick("R8 sleep");
    chk(settle_o == 1'b0, "R8 cut by sleep", int'(settle_o), 0);
    bias_wr = 1'b1; tick("R8 sleep strobe");
    pwr_mode = 2'b11; measure(n, "R8 resume");
    chk(n == 0, "R8 no resume after cut", n, 0);
    // R9 code change during pulse uses value at trigger
    set_code(0);
    head_chg = 1'b1; code_din = 3'd7; code_wr = 1'b1;
    measure(n, "R9 same-edge");
    chk(n == 150, "R9 old code at trigger edge", n, 150);
    head_chg = 1'b1; measure(n, "R9 new");
    chk(n == 106, "R9 new code used", n, 106);
    // random phase against model
    for (int i = 0; i < 20000; i++) begin
      if ($urandom % 10 == 0) begin
        int r = $urandom % 8;
        pwr_mode = (r < 5) ? 2'b11 : 2'(r);
        rd_wr_n = ($urandom % 3) != 0;
      end
      if ($urandom % 50 == 0) keep_biased = $urandom % 2;
      head_chg = ($urandom % 40) == 0;
      bias_wr  = ($urandom % 40) == 0;
      if ($urandom % 80 == 0) begin code_wr = 1'b1; code_din = 3'($urandom); end
      tick("R2-model R3 R4 R5 R6 R7 R8 R9");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule